// File: doc/BRIEF.md
# Cascadable Prescaled Timer Bank

A bank of four 16-bit up-counters behind a small register bus. Each timer has a reload register, a control register and a live counter that can be read back. A running timer advances either on ticks from its own prescaler or on the overflows of the timer one index below it. The second choice lets two or more timers be chained into a wider count.

When a counter steps past its all-ones value, it reloads from its reload register. If its interrupt enable is set, it also raises a one-cycle request on its own line of `irq`. Software writes a reload value and then a control word to start a timer. It reads the counter at any time, and it clears the enable bit to freeze the count where it stands.

Bus accesses are single-cycle. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`.

Top module: `tmr_bank`

## Requirements
- R1: Register map. `bus_addr[2:1]` selects the timer. With `bus_addr[0]`=0, a write sets the reload register and a read returns the live counter. With `bus_addr[0]`=1, both reach the control register.
- R2: Only control bits 0, 1, 2, 6 and 7 are kept (write mask 0x00C7). Every other control bit reads back as 0.
- R3: Control bits 1:0 pick the divide ratio: 00 gives 1, 01 gives 64, 10 gives 256 and 11 gives 1024. A timer enabled at edge W with ratio N (bit 2 clear) steps at edges W+N, W+2N, and so on.
- R4: A write that moves control bit 7 (enable) from 0 to 1 loads the counter with the reload value at that edge and restarts the prescaler from zero.
- R5: A counter stepping from 0xFFFF loads the reload value instead, so overflows repeat every (0x10000 − reload) steps.
- R6: If control bit 6 is set, `irq[i]` is high for exactly the one cycle after the edge at which timer i wrapped. No pulse is produced otherwise.
- R7: With control bit 2 set, timer i>0 ignores its prescaler and steps once for each overflow of timer i−1, at the same edge. Timer 0 in this mode never steps.
- R8: Writing the reload register leaves the running count untouched. The new value is used at the next wrap or enable.
- R9: Clearing the enable bit freezes the counter, and later reads return the frozen value. The step due at the disabling edge itself still happens.
- R10: Changing bits 1:0 of a running timer restarts its prescaler from zero at that write, so the next step comes N cycles later.
- R11: After reset, every counter, reload register, control register and `irq` line is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Timer index in bits 2:1, register select in bit 0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Live counter or control word of the addressed timer |
| irq | output | 4 | Per-timer overflow request pulses |

## Verification
The assertions assume that at most one register changes per edge. As a result, an enable edge never coincides with a reload write to the same timer, and the wrap check can compare against the reload value held one cycle earlier. The bench drives exactly one write per cycle from a single task and changes inputs only on falling edges. It schedules each disable and prescale change on an edge where the step in flight can be predicted, and avoids edges where the old and new settings would both apply.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W = 10;
  localparam int CTRL_W = 8;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'hC7;
  localparam int B_CASC = 2;
  localparam int B_IE = 6;
  localparam int B_EN = 7;

  // log2 of the divide ratio for a prescale select code
  function automatic logic [3:0] presc_shift(input logic [1:0] sel);
    case (sel)
      2'd0: return 4'd0;
      2'd1: return 4'd6;
      2'd2: return 4'd8;
      default: return 4'd10;
    endcase
  endfunction

  // true in the cycle where the prescaler completes one divide period
  function automatic logic presc_due(input logic [PRE_W-1:0] pre, input logic [1:0] sel);
    logic [PRE_W-1:0] m;
    m = PRE_W'((1 << presc_shift(sel)) - 1);
    return (pre & m) == m;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run)     pre_q <= pre_q + 1'b1;
  end

  assign tick = run && presc_due(pre_q, sel);

  // R10: a restart leaves the next tick of a coarse ratio at least a full period away
  a_r10_restart_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && sel != 2'd0) |=> !tick);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_reload,
  input  logic              wr_ctrl,
  input  logic [CW-1:0]     wdata,
  input  logic              casc_in,
  output logic [CW-1:0]     cnt,
  output logic [CTRL_W-1:0] ctrl,
  output logic              ovf,
  output logic              irq
);
  logic [CW-1:0]     reload_q;
  logic [CW-1:0]     cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_new;
  logic en, en_rise, sel_chg, tick, step;

  assign ctrl_new = wdata[CTRL_W-1:0] & CTRL_WMASK;
  assign en       = ctrl_q[B_EN];
  assign en_rise  = wr_ctrl && !en && ctrl_new[B_EN];
  assign sel_chg  = wr_ctrl && (ctrl_new[1:0] != ctrl_q[1:0]);

  tmr_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .restart (en_rise || sel_chg),
    .sel     (ctrl_q[1:0]),
    .tick    (tick)
  );

  assign step = en && (ctrl_q[B_CASC] ? casc_in : tick);
  assign ovf  = step && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      cnt_q    <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_ctrl)   ctrl_q   <= ctrl_new;
      if (en_rise)   cnt_q    <= reload_q;
      else if (ovf)  cnt_q    <= reload_q;
      else if (step) cnt_q    <= cnt_q + 1'b1;
      irq <= ovf && ctrl_q[B_IE];
    end
  end

  assign cnt  = cnt_q;
  assign ctrl = ctrl_q;

  a_r4_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> cnt_q == $past(reload_q));
  a_r5_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q == $past(reload_q));
  a_r6_irq_after_top: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cnt_q) == '1 && $past(en)));
  a_r8_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reload && !step && !en_rise) |=> $stable(cnt_q));
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !en_rise) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM = 4,
  parameter int CW  = 16,
  localparam int IW = $clog2(NUM),
  localparam int AW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [NUM-1:0] irq
);
  logic [CW-1:0]     cnt_a  [NUM];
  logic [CTRL_W-1:0] ctrl_a [NUM];
  logic [NUM-1:0]    ovf_a;
  logic [IW-1:0]     idx;

  assign idx = bus_addr[AW-1:1];

  for (genvar i = 0; i < NUM; i++) begin : g_tmr
    logic casc_src;
    if (i == 0) begin : g_bottom
      assign casc_src = 1'b0;
    end else begin : g_link
      assign casc_src = ovf_a[i-1];
    end
    tmr_chan #(.CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_reload (bus_we && idx == IW'(i) && !bus_addr[0]),
      .wr_ctrl   (bus_we && idx == IW'(i) && bus_addr[0]),
      .wdata     (bus_wdata),
      .casc_in   (casc_src),
      .cnt       (cnt_a[i]),
      .ctrl      (ctrl_a[i]),
      .ovf       (ovf_a[i]),
      .irq       (irq[i])
    );
  end

  assign bus_rdata = bus_addr[0] ? CW'(ctrl_a[idx]) : cnt_a[idx];

  // R2: unwritable control bits read as zero
  a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[0] |-> (bus_rdata & ~CW'(CTRL_WMASK)) == '0);
  // R7: timer 0 chained to nothing never moves unless re-enabled
  a_r7_bottom_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_a[0][B_CASC] && !(bus_we && idx == '0 && bus_addr[0])) |=> $stable(cnt_a[0]));
endmodule

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq;

  int cyc = 0;
  int last_w = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { int ch; int stamp; } ev_t;
  ev_t exp_q[$];

  tmr_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    last_w = cyc;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input int exp);
    bus_addr = a;
    #1;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic wait_to(input int stamp);
    while (cyc < stamp) @(negedge clk);
  endtask

  task automatic push(input int ch, input int stamp);
    ev_t e;
    e.ch = ch; e.stamp = stamp;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor for R6 pulses
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int ch = 0; ch < 4; ch++) begin
        if (irq[ch]) begin
          n_tests++;
          if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R6 unexpected irq ch=%0d at %0d expected none", ch, cyc);
          end else begin
            ev_t e;
            e = exp_q.pop_front();
            if (e.ch != ch || e.stamp != cyc) begin
              n_fail++;
              $display("FAIL R6 irq actual ch=%0d t=%0d expected ch=%0d t=%0d",
                       ch, cyc, e.ch, e.stamp);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    for (int t = 0; t < 4; t++) begin
      rd("R11 counter", 3'(t * 2), 0);
      rd("R11 control", 3'(t * 2 + 1), 0);
    end
    chk("R11 irq", int'(irq), 0);

    // R2 / R1 control mask
    wr(3'd1, 16'hFF3B);
    rd("R2 ctrl mask", 3'd1, 16'h0003);
    wr(3'd1, 16'h0000);

    // R7 timer 0 chained to nothing stays put
    wr(3'd0, 16'h1234);
    wr(3'd1, 16'h0084);
    w = last_w;
    wait_to(w + 50);
    rd("R7 timer0 cascade idle", 3'd0, 16'h1234);
    wr(3'd1, 16'h0000);

    // R7 cascade: timer1 counts timer0 wraps, R6 pulses on timer1
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h00C4);
    wr(3'd0, 16'hFFFE);
    wr(3'd1, 16'h0080);
    w = last_w;
    for (int k = 1; k <= 4; k++) push(1, w + 2 * k);
    wait_to(w + 7);
    wr(3'd1, 16'h0000);
    rd("R7 cascade counter", 3'd2, 16'hFFFF);
    wr(3'd3, 16'h0000);

    // R3 divide by one, R1 live read
    wr(3'd4, 16'h1000);
    wr(3'd5, 16'h0080);
    w = last_w;
    wait_to(w + 37);
    rd("R3 div1 live count", 3'd4, 16'h1025);
    wr(3'd5, 16'h0000);

    // R8 reload write, R5 period, R9 freeze
    wr(3'd6, 16'hFFF0);
    wr(3'd7, 16'h00C0);
    w = last_w;
    push(3, w + 16);
    push(3, w + 24);
    wait_to(w + 2);
    wr(3'd6, 16'hFFF8);
    wait_to(w + 5);
    rd("R8 count undisturbed", 3'd6, 16'hFFF5);
    wait_to(w + 27);
    wr(3'd7, 16'h0000);
    rd("R9 frozen value", 3'd6, 16'hFFFC);
    wait_to(w + 40);
    rd("R9 still frozen", 3'd6, 16'hFFFC);
    rd("R2 ctrl cleared", 3'd7, 0);

    // R4 enable loads reload value
    wr(3'd7, 16'h0080);
    rd("R4 enable load", 3'd6, 16'hFFF8);
    wr(3'd7, 16'h0000);
    rd("R9 freeze after step", 3'd6, 16'hFFF9);

    // R3 divide by 64 with R5 wrap pulses
    wr(3'd4, 16'hFFFE);
    wr(3'd5, 16'h00C1);
    w = last_w;
    push(2, w + 128);
    push(2, w + 256);
    wait_to(w + 100);
    rd("R3 div64 step", 3'd4, 16'hFFFF);
    wait_to(w + 260);
    wr(3'd5, 16'h0000);

    // R3 divide by 1024
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'h00C3);
    w = last_w;
    push(0, w + 1024);
    push(0, w + 2048);
    wait_to(w + 2050);
    wr(3'd1, 16'h0000);

    // R10 prescale change restarts, R3 divide by 256
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0081);
    w = last_w;
    wait_to(w + 99);
    wr(3'd3, 16'h0082);
    c = last_w;
    rd("R10 count at change", 3'd2, 1);
    wait_to(c + 255);
    rd("R10 no step before period", 3'd2, 1);
    wait_to(c + 256);
    rd("R10 step after restart", 3'd2, 2);
    wait_to(c + 600);
    rd("R3 div256 count", 3'd2, 3);
    wr(3'd3, 16'h0000);

    repeat (5) @(negedge clk);
    chk("R6 all pulses seen", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule